// File: doc/BRIEF.md
# Configuration Cycle Router

This block sits between a host bridge and the configuration paths of a chip. The host first writes a 32-bit configuration address word that names a bus, device, function and register. It then makes a data-phase access. On each enabled data-phase access the block decides where the configuration cycle goes. It can go to one of two internal bridge devices. It can be forwarded downstream as a hub cycle. It can also be issued as a Type 0 or Type 1 cycle on a secondary graphics bus. For a Type 0 graphics cycle the block also produces a one-hot device select.

The decision compares the bus field with a secondary bus number and a subordinate bus number. Both values come from the bridge's own settings. The result is registered. It appears one cycle after the access strobe as a single-cycle valid pulse. The pulse carries a destination code and the outgoing address for the chosen path. The address word is held in the block and can be read back at any time.

Top module: `cfg_cycle_router`

## Requirements
- R1: After reset the address word reads back as 0 and `rt_valid` is 0.
- R2: A write stores the address word. On readback, bits 30:24 and 1:0 are always 0 and the other bits hold the written value. Field positions: enable bit 31, bus [23:16], device [15:11], function [10:8], register [7:2].
- R3: While enable bit 31 is 0, a data-phase strobe produces no `rt_valid` pulse.
- R4: Bus 0 with device 0 or 1 and function 0 gives destination code 0 (internal). `int_dev` equals the device number and `int_reg` equals the register field.
- R5: Bus 0 with device 0 or 1 and a non-zero function gives code 5 (dropped). `rt_read_ones` is 1 for a read and 0 for a write.
- R6: Bus 0 with device 2 to 31 gives code 1 (hub). `hub_addr` is {16'h0, device, function, register, 2'b00}.
- R7: A non-zero bus equal to the secondary number with device 0 to 15 gives code 2 (graphics Type 0). `gfx_addr[31:16]` has only bit device set, [15:2] holds device, function and register, and [1:0] is 00.
- R8: A non-zero bus equal to the secondary number with device 16 to 31 gives code 4 (abort). `rt_master_abort` pulses with `rt_valid` and `gfx_addr[31:16]` is 0.
- R9: A bus above the secondary number and at or below the subordinate number gives code 3 (graphics Type 1). `gfx_addr` is {8'h0, bus, device, function, register, 2'b01}.
- R10: Any other non-zero bus gives code 1 (hub). `hub_addr` is {8'h0, bus, device, function, register, 2'b01}.
- R11: `rt_valid` is high for exactly the one cycle after an enabled strobe. The address path that was not chosen reads 0. A write in the same cycle as the strobe does not affect that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_wr_en | input | 1 | Write strobe for the address word |
| addr_wr_data | input | 32 | Address word to store |
| addr_rd_data | output | 32 | Stored address word, reserved bits zero |
| sec_bus | input | 8 | Secondary bus number |
| sub_bus | input | 8 | Subordinate bus number |
| acc_strobe | input | 1 | Data-phase configuration access |
| acc_is_read | input | 1 | Access is a read |
| rt_valid | output | 1 | Routing result valid, one cycle |
| rt_dest | output | 3 | Destination code |
| rt_master_abort | output | 1 | Type 0 graphics access with no device select |
| rt_read_ones | output | 1 | Dropped read, return all ones |
| int_dev | output | 1 | Selected internal device |
| int_reg | output | 6 | Register index for the internal device |
| hub_addr | output | 32 | Outgoing hub configuration address |
| gfx_addr | output | 32 | Outgoing graphics configuration address |

## Verification
The hardest cases to reach are at the range edges: a bus equal to the secondary number, one above it, exactly the subordinate number, and one past it. Device numbers 15 and 16 sit on the two sides of the select range. The bench programs the secondary and subordinate numbers itself. It then aims an address word at each of these edges. It also places a write in the same cycle as a strobe, to show that the routed access still uses the earlier word.

// File: rtl/cfgr_pkg.sv
package cfgr_pkg;

  localparam int ADDR_W  = 32;
  localparam int BUS_W   = 8;
  localparam int DEV_W   = 5;
  localparam int FN_W    = 3;
  localparam int REG_W   = 6;
  localparam int IDSEL_N = 16;
  localparam int LOW_W   = DEV_W + FN_W + REG_W;

  typedef enum logic [2:0] {
    DST_INT   = 3'd0,
    DST_HUB   = 3'd1,
    DST_GFX0  = 3'd2,
    DST_GFX1  = 3'd3,
    DST_ABORT = 3'd4,
    DST_DROP  = 3'd5
  } cfgr_dest_e;

  typedef struct packed {
    logic             en;
    logic [BUS_W-1:0] bus;
    logic [DEV_W-1:0] dev;
    logic [FN_W-1:0]  fn;
    logic [REG_W-1:0] rg;
  } cfgr_fields_t;

  function automatic cfgr_fields_t split_word(input logic [ADDR_W-1:0] w);
    cfgr_fields_t f;
    f.en  = w[31];
    f.bus = w[23:16];
    f.dev = w[15:11];
    f.fn  = w[10:8];
    f.rg  = w[7:2];
    return f;
  endfunction

  function automatic logic [ADDR_W-1:0] join_word(input cfgr_fields_t f);
    return {f.en, 7'd0, f.bus, f.dev, f.fn, f.rg, 2'b00};
  endfunction

  function automatic logic [LOW_W-1:0] low_part(input cfgr_fields_t f);
    return {f.dev, f.fn, f.rg};
  endfunction

  function automatic cfgr_dest_e pick_dest(input cfgr_fields_t f,
                                           input logic [BUS_W-1:0] sec,
                                           input logic [BUS_W-1:0] sub);
    if (f.bus == '0) begin
      if (f.dev < DEV_W'(2)) return (f.fn == '0) ? DST_INT : DST_DROP;
      return DST_HUB;
    end
    if (f.bus == sec) return (f.dev < DEV_W'(IDSEL_N)) ? DST_GFX0 : DST_ABORT;
    if (f.bus > sec && f.bus <= sub) return DST_GFX1;
    return DST_HUB;
  endfunction

endpackage

// File: rtl/cfgr_addr_reg.sv
module cfgr_addr_reg
  import cfgr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_data,
  output cfgr_fields_t      fields,
  output logic [ADDR_W-1:0] rd_data
);
  cfgr_fields_t held_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     held_q <= '0;
    else if (wr_en) held_q <= split_word(wr_data);
  end

  assign fields  = held_q;
  assign rd_data = join_word(held_q);
endmodule

// File: rtl/cfgr_route_decode.sv
module cfgr_route_decode
  import cfgr_pkg::*;
(
  input  cfgr_fields_t      fields,
  input  logic [BUS_W-1:0]  sec_bus,
  input  logic [BUS_W-1:0]  sub_bus,
  output cfgr_dest_e        dest,
  output logic              is_local,
  output logic              sec_hit,
  output logic              in_range
);
  assign is_local = (fields.bus == '0) && (fields.dev < DEV_W'(2));
  assign sec_hit  = (fields.bus != '0) && (fields.bus == sec_bus);
  assign in_range = (fields.bus != '0) && (fields.bus > sec_bus) &&
                    (fields.bus <= sub_bus);
  assign dest     = pick_dest(fields, sec_bus, sub_bus);
endmodule

// File: rtl/cfgr_addr_map.sv
module cfgr_addr_map
  import cfgr_pkg::*;
(
  input  cfgr_fields_t      fields,
  input  cfgr_dest_e        dest,
  output logic [ADDR_W-1:0] hub_addr,
  output logic [ADDR_W-1:0] gfx_addr,
  output logic [IDSEL_N-1:0] idsel
);
  localparam int SEL_W = $clog2(IDSEL_N);

  for (genvar i = 0; i < IDSEL_N; i++) begin : g_sel
    assign idsel[i] = (fields.dev < DEV_W'(IDSEL_N)) &&
                      (fields.dev[SEL_W-1:0] == SEL_W'(i));
  end

  always_comb begin
    hub_addr = '0;
    gfx_addr = '0;
    unique case (dest)
      DST_HUB: begin
        if (fields.bus == '0) hub_addr = {16'd0, low_part(fields), 2'b00};
        else                  hub_addr = {8'd0, fields.bus, low_part(fields), 2'b01};
      end
      DST_GFX0:  gfx_addr = {idsel, low_part(fields), 2'b00};
      DST_ABORT: gfx_addr = {16'd0, low_part(fields), 2'b00};
      DST_GFX1:  gfx_addr = {8'd0, fields.bus, low_part(fields), 2'b01};
      default: ;
    endcase
  end
endmodule

// File: rtl/cfg_cycle_router.sv
module cfg_cycle_router
  import cfgr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_wr_en,
  input  logic [31:0]       addr_wr_data,
  output logic [31:0]       addr_rd_data,
  input  logic [7:0]        sec_bus,
  input  logic [7:0]        sub_bus,
  input  logic              acc_strobe,
  input  logic              acc_is_read,
  output logic              rt_valid,
  output logic [2:0]        rt_dest,
  output logic              rt_master_abort,
  output logic              rt_read_ones,
  output logic              int_dev,
  output logic [5:0]        int_reg,
  output logic [31:0]       hub_addr,
  output logic [31:0]       gfx_addr
);
  cfgr_fields_t         fields;
  cfgr_dest_e           dec_dest;
  logic                 dec_local, dec_sec_hit, dec_in_range;
  logic [ADDR_W-1:0]    map_hub, map_gfx;
  logic [IDSEL_N-1:0]   map_idsel;
  logic                 fire;

  cfgr_addr_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(addr_wr_en), .wr_data(addr_wr_data),
    .fields(fields), .rd_data(addr_rd_data)
  );

  cfgr_route_decode u_dec (
    .fields(fields), .sec_bus(sec_bus), .sub_bus(sub_bus), .dest(dec_dest),
    .is_local(dec_local), .sec_hit(dec_sec_hit), .in_range(dec_in_range)
  );

  cfgr_addr_map u_map (
    .fields(fields), .dest(dec_dest), .hub_addr(map_hub), .gfx_addr(map_gfx),
    .idsel(map_idsel)
  );

  assign fire = acc_strobe && fields.en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rt_valid        <= 1'b0;
      rt_dest         <= DST_INT;
      rt_master_abort <= 1'b0;
      rt_read_ones    <= 1'b0;
      int_dev         <= 1'b0;
      int_reg         <= '0;
      hub_addr        <= '0;
      gfx_addr        <= '0;
    end else begin
      rt_valid        <= fire;
      rt_master_abort <= fire && (dec_dest == DST_ABORT);
      rt_read_ones    <= fire && (dec_dest == DST_DROP) && acc_is_read;
      if (fire) begin
        rt_dest  <= dec_dest;
        int_dev  <= fields.dev[0];
        int_reg  <= fields.rg;
        hub_addr <= map_hub;
        gfx_addr <= map_gfx;
      end
    end
  end
endmodule

// File: rtl/cfg_cycle_router_chk.sv
module cfg_cycle_router_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_strobe,
  input logic [31:0] addr_rd_data,
  input logic        rt_valid,
  input logic [2:0]  rt_dest,
  input logic        rt_master_abort,
  input logic        rt_read_ones,
  input logic [31:0] hub_addr,
  input logic [31:0] gfx_addr,
  input logic        dec_local
);
  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    addr_rd_data[30:24] == 7'd0 && addr_rd_data[1:0] == 2'b00);

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe && !addr_rd_data[31] |=> !rt_valid);

  assert_valid_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe && addr_rd_data[31] |=> rt_valid);

  assert_valid_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid |-> $past(acc_strobe));

  assert_idsel_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && rt_dest == 3'd2 |-> $countones(gfx_addr[31:16]) == 1 && hub_addr == 32'd0);

  assert_abort_nosel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rt_master_abort |-> rt_valid && rt_dest == 3'd4 && gfx_addr[31:16] == 16'd0);

  assert_ones_dropped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rt_read_ones |-> rt_valid && rt_dest == 3'd5);

  assert_local_route_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_strobe && addr_rd_data[31] && dec_local |=> rt_dest == 3'd0 || rt_dest == 3'd5);

  assert_hub_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rt_valid && rt_dest == 3'd1 |-> gfx_addr == 32'd0);
endmodule

bind cfg_cycle_router cfg_cycle_router_chk chk_i (
  .clk(clk), .rst_n(rst_n), .acc_strobe(acc_strobe), .addr_rd_data(addr_rd_data),
  .rt_valid(rt_valid), .rt_dest(rt_dest), .rt_master_abort(rt_master_abort),
  .rt_read_ones(rt_read_ones), .hub_addr(hub_addr), .gfx_addr(gfx_addr),
  .dec_local(dec_local)
);

// File: tb/cfg_cycle_router_tb.sv
module cfg_cycle_router_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic addr_wr_en = 1'b0;
  logic [31:0] addr_wr_data = '0;
  logic [31:0] addr_rd_data;
  logic [7:0] sec_bus = 8'd4;
  logic [7:0] sub_bus = 8'd9;
  logic acc_strobe = 1'b0;
  logic acc_is_read = 1'b0;
  logic rt_valid, rt_master_abort, rt_read_ones, int_dev;
  logic [2:0] rt_dest;
  logic [5:0] int_reg;
  logic [31:0] hub_addr, gfx_addr;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_cycle_router dut_i (
    .clk(clk), .rst_n(rst_n), .addr_wr_en(addr_wr_en), .addr_wr_data(addr_wr_data),
    .addr_rd_data(addr_rd_data), .sec_bus(sec_bus), .sub_bus(sub_bus),
    .acc_strobe(acc_strobe), .acc_is_read(acc_is_read), .rt_valid(rt_valid),
    .rt_dest(rt_dest), .rt_master_abort(rt_master_abort), .rt_read_ones(rt_read_ones),
    .int_dev(int_dev), .int_reg(int_reg), .hub_addr(hub_addr), .gfx_addr(gfx_addr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input logic [7:0] b, input int d, input int f, input int r);
    return 32'h8000_0000 | (32'(b) << 16) | (32'(d) << 11) | (32'(f) << 8) | (32'(r) << 2);
  endfunction

  // write word, strobe, sample one cycle after the strobe edge
  task automatic access(input logic [31:0] w, input logic rd);
    @(negedge clk); addr_wr_en = 1'b1; addr_wr_data = w;
    @(negedge clk); addr_wr_en = 1'b0; acc_strobe = 1'b1; acc_is_read = rd;
    @(negedge clk); acc_strobe = 1'b0; acc_is_read = 1'b0;
  endtask

  task automatic t_reset;
    check("R1 rd", addr_rd_data, 32'd0);
    check("R1 valid", {31'd0, rt_valid}, 32'd0);
  endtask

  task automatic t_regrw;
    @(negedge clk); addr_wr_en = 1'b1; addr_wr_data = 32'hFFFF_FFFF;
    @(negedge clk); addr_wr_en = 1'b0;
    check("R2 all ones", addr_rd_data, 32'h80FF_FFFC);
    @(negedge clk); addr_wr_en = 1'b1; addr_wr_data = 32'h7F12_3457;
    @(negedge clk); addr_wr_en = 1'b0;
    check("R2 pattern", addr_rd_data, 32'h0012_3454);
  endtask

  task automatic t_disabled;
    access(word(8'd0, 0, 0, 1) & 32'h7FFF_FFFF, 1'b1);
    check("R3 no valid", {31'd0, rt_valid}, 32'd0);
  endtask

  task automatic t_internal;
    for (int d = 0; d < 2; d++) begin
      access(word(8'd0, d, 0, 6'h2A), 1'b1);
      check("R4 valid", {31'd0, rt_valid}, 32'd1);
      check("R4 dest", {29'd0, rt_dest}, 32'd0);
      check("R4 dev", {31'd0, int_dev}, 32'(d));
      check("R4 reg", {26'd0, int_reg}, 32'h2A);
      check("R4 ones", {31'd0, rt_read_ones}, 32'd0);
    end
  endtask

  task automatic t_drop;
    access(word(8'd0, 1, 3, 5), 1'b1);
    check("R5 dest", {29'd0, rt_dest}, 32'd5);
    check("R5 read ones", {31'd0, rt_read_ones}, 32'd1);
    access(word(8'd0, 0, 7, 5), 1'b0);
    check("R5 write", {31'd0, rt_read_ones}, 32'd0);
  endtask

  task automatic t_hub_local;
    access(word(8'd0, 2, 1, 3), 1'b0);
    check("R6 dest", {29'd0, rt_dest}, 32'd1);
    check("R6 addr", hub_addr, (32'd2 << 11) | (32'd1 << 8) | (32'd3 << 2));
    access(word(8'd0, 31, 0, 0), 1'b0);
    check("R6 dev31", hub_addr, 32'd31 << 11);
    check("R11 gfx zero", gfx_addr, 32'd0);
  endtask

  task automatic t_gfx0;
    int devs[3] = '{0, 7, 15};
    foreach (devs[i]) begin
      access(word(sec_bus, devs[i], 2, 9), 1'b1);
      check("R7 dest", {29'd0, rt_dest}, 32'd2);
      check("R7 addr", gfx_addr,
            (32'h1 << (16 + devs[i])) | (32'(devs[i]) << 11) | (32'd2 << 8) | (32'd9 << 2));
      check("R7 abort", {31'd0, rt_master_abort}, 32'd0);
    end
  endtask

  task automatic t_abort;
    int devs[2] = '{16, 31};
    foreach (devs[i]) begin
      access(word(sec_bus, devs[i], 0, 1), 1'b1);
      check("R8 dest", {29'd0, rt_dest}, 32'd4);
      check("R8 abort", {31'd0, rt_master_abort}, 32'd1);
      check("R8 nosel", {16'd0, gfx_addr[31:16]}, 32'd0);
    end
    @(negedge clk);
    check("R8 pulse", {31'd0, rt_master_abort}, 32'd0);
  endtask

  task automatic t_gfx1;
    logic [7:0] buses[2] = '{8'd5, 8'd9};
    foreach (buses[i]) begin
      access(word(buses[i], 3, 1, 4), 1'b0);
      check("R9 dest", {29'd0, rt_dest}, 32'd3);
      check("R9 addr", gfx_addr,
            (32'(buses[i]) << 16) | (32'd3 << 11) | (32'd1 << 8) | (32'd4 << 2) | 32'd1);
      check("R11 hub zero", hub_addr, 32'd0);
    end
  endtask

  task automatic t_hub_remote;
    logic [7:0] buses[3] = '{8'd10, 8'd3, 8'd255};
    foreach (buses[i]) begin
      access(word(buses[i], 4, 0, 2), 1'b0);
      check("R10 dest", {29'd0, rt_dest}, 32'd1);
      check("R10 addr", hub_addr, (32'(buses[i]) << 16) | (32'd4 << 11) | (32'd2 << 2) | 32'd1);
    end
  endtask

  task automatic t_timing;
    @(negedge clk); addr_wr_en = 1'b1; addr_wr_data = word(8'd0, 5, 0, 1);
    @(negedge clk); addr_wr_data = word(sec_bus, 1, 0, 1); acc_strobe = 1'b1;
    @(negedge clk); addr_wr_en = 1'b0; acc_strobe = 1'b0;
    check("R11 valid", {31'd0, rt_valid}, 32'd1);
    check("R11 old word", {29'd0, rt_dest}, 32'd1);
    @(negedge clk);
    check("R11 one cycle", {31'd0, rt_valid}, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regrw();
    t_disabled();
    t_internal();
    t_drop();
    t_hub_local();
    t_gfx0();
    t_abort();
    t_gfx1();
    t_hub_remote();
    t_timing();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule